// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small set of binary ownership tokens that two requesters, called the left port and the right port, share. Each port addresses the bank with a strobe of its own that only qualifies semaphore writes; it is independent of any memory select. Each port also supplies a flag index, a write enable and a single data bit. A port asks for a flag by writing 0 and gives it back by writing 1. It learns whether it holds the flag by looking at its read bit. The flags guard nothing in hardware. Software gives them their meaning, and no access is ever stalled.

A request for a flag that the other side holds is not lost. It stays pending and turns into ownership on the same clock edge at which the holder gives the flag back. When both sides ask for the same free flag in the same cycle, the left port wins and the right port's request stays pending. Two owners of one flag can therefore never exist.

Top module: `sem_flag_bank`

## Requirements
- R1: The bank has NFLAGS (default 8) independent flags, selected by an index of clog2(NFLAGS) bits. An action on one flag leaves every other flag unchanged.
- R2: A write takes effect only when the port's semaphore strobe and its write enable are both 1. Without both, ownership and pending state stay unchanged.
- R3: At no time do both ports own the same flag.
- R4: A write of data 0 to a flag that is free and has no pending request from the other port makes the writer the owner at that clock edge.
- R5: The read bit of a port, l_rd or r_rd, is combinational from the stored state. It is 0 when that port owns the flag at its current index and 1 otherwise, whatever the strobe is.
- R6: A write of data 0 to a flag that the other port owns leaves the request pending. It is granted at the edge where the owner writes 1 to that flag.
- R7: When both ports write 0 to the same free flag in one cycle, the left port becomes the owner and the right port's request stays pending.
- R8: A write of data 1 by a port that does not own the flag leaves the owner unchanged and withdraws that port's own pending request.
- R9: After reset every flag is free with nothing pending, and both read bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore strobe |
| l_we | input | 1 | Left write enable |
| l_idx | input | IW | Left flag index |
| l_wd | input | 1 | Left write bit: 0 request, 1 release |
| l_rd | output | 1 | Left status: 0 owned by left |
| r_sel | input | 1 | Right semaphore strobe |
| r_we | input | 1 | Right write enable |
| r_idx | input | IW | Right flag index |
| r_wd | input | 1 | Right write bit: 0 request, 1 release |
| r_rd | output | 1 | Right status: 0 owned by right |

## Verification
The assertions assume that all inputs are synchronous to clk and settle before each rising edge. They place no limit on which combinations occur. Ties, releases by a port that does not own the flag, and repeated requests by the owner are all legal. The stimulus drives inputs only on falling edges. Its random phase draws indexes from a narrow range, so that collisions on one flag and handoffs happen often. The directed part forces exact ties, releases by a non-owner, and writes with the strobe off.

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int NFLAGS = 8,
  localparam int IW = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_we,
  input  logic [IW-1:0] l_idx,
  input  logic          l_wd,
  output logic          l_rd,
  input  logic          r_sel,
  input  logic          r_we,
  input  logic [IW-1:0] r_idx,
  input  logic          r_wd,
  output logic          r_rd
);

  logic [NFLAGS-1:0] own_l, own_r, pnd_l, pnd_r;
  logic [NFLAGS-1:0] lhit, rhit, lreq, lrel, rreq, rrel;
  logic [NFLAGS-1:0] ol_m, or_m, pl_m, pr_m, free_m, gl, gr;

  assign lhit = (l_sel && l_we) ? (NFLAGS'(1) << l_idx) : '0;
  assign rhit = (r_sel && r_we) ? (NFLAGS'(1) << r_idx) : '0;
  assign lreq = lhit & {NFLAGS{~l_wd}};
  assign lrel = lhit & {NFLAGS{l_wd}};
  assign rreq = rhit & {NFLAGS{~r_wd}};
  assign rrel = rhit & {NFLAGS{r_wd}};

  assign ol_m   = own_l & ~lrel;
  assign or_m   = own_r & ~rrel;
  assign pl_m   = (pnd_l | lreq) & ~lrel & ~ol_m;
  assign pr_m   = (pnd_r | rreq) & ~rrel & ~or_m;
  assign free_m = ~ol_m & ~or_m;
  assign gl     = free_m & pl_m;
  assign gr     = free_m & ~pl_m & pr_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_l <= '0;
      own_r <= '0;
      pnd_l <= '0;
      pnd_r <= '0;
    end else begin
      own_l <= ol_m | gl;
      own_r <= or_m | gr;
      pnd_l <= pl_m & ~gl;
      pnd_r <= pr_m & ~gr;
    end
  end

  assign l_rd = ~own_l[l_idx];
  assign r_rd = ~own_r[r_idx];

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_sel && l_we) && !(r_sel && r_we)) |=>
      ($stable(own_l) && $stable(own_r) && $stable(pnd_l) && $stable(pnd_r)));

  for (genvar i = 0; i < NFLAGS; i++) begin : g_chk
    assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({own_l[i], own_r[i]}));

    assert_wait_l_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pnd_l[i] |-> own_r[i]);

    assert_wait_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pnd_r[i] |-> own_l[i]);

    assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && pnd_r[i] && l_sel && l_we && l_wd && l_idx == IW'(i) &&
       !(r_sel && r_we && r_idx == IW'(i))) |=> own_r[i]);

    assert_tie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l[i] && !own_r[i] && l_sel && l_we && !l_wd && l_idx == IW'(i) &&
       r_sel && r_we && !r_wd && r_idx == IW'(i)) |=> (own_l[i] && pnd_r[i]));

    assert_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l[i] && !own_r[i] && !pnd_r[i] && l_sel && l_we && !l_wd &&
       l_idx == IW'(i)) |=> own_l[i]);
  end

endmodule

// File: tb/tb_sem_flag_bank.sv
`timescale 1ns/1ps
module tb_sem_flag_bank;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_we = 0, l_wd = 0, r_sel = 0, r_we = 0, r_wd = 0;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic l_rd, r_rd;

  int vecs = 0, errs = 0;
  int mo [N];
  bit mpl [N], mpr [N];

  always #2.5 clk = ~clk;

  sem_flag_bank #(.NFLAGS(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_we(l_we), .l_idx(l_idx), .l_wd(l_wd), .l_rd(l_rd),
    .r_sel(r_sel), .r_we(r_we), .r_idx(r_idx), .r_wd(r_wd), .r_rd(r_rd));

  function automatic bit exp_rd(int side, int idx);
    return !(mo[idx] == side);
  endfunction

  task automatic model_step(bit ls, bit lw, int li, bit ld, bit rs, bit rw, int ri, bit rdd);
    for (int i = 0; i < N; i++) begin
      bit lrq = ls && lw && li == i && !ld;
      bit lrl = ls && lw && li == i && ld;
      bit rrq = rs && rw && ri == i && !rdd;
      bit rrl = rs && rw && ri == i && rdd;
      if (lrl && mo[i] == 1) mo[i] = 0;
      if (rrl && mo[i] == 2) mo[i] = 0;
      if (lrq) mpl[i] = 1;
      if (rrq) mpr[i] = 1;
      if (lrl) mpl[i] = 0;
      if (rrl) mpr[i] = 0;
      if (mo[i] == 1) mpl[i] = 0;
      if (mo[i] == 2) mpr[i] = 0;
      if (mo[i] == 0 && mpl[i]) begin mo[i] = 1; mpl[i] = 0; end
      else if (mo[i] == 0 && mpr[i]) begin mo[i] = 2; mpr[i] = 0; end
    end
  endtask

  task automatic check(string req, logic act, bit exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit ls, bit lw, int li, bit ld, bit rs, bit rw, int ri, bit rdd, string req);
    @(negedge clk);
    l_sel = ls; l_we = lw; l_idx = IW'(li); l_wd = ld;
    r_sel = rs; r_we = rw; r_idx = IW'(ri); r_wd = rdd;
    #1;
    check({req, " left"}, l_rd, exp_rd(1, li));
    check({req, " right"}, r_rd, exp_rd(2, ri));
    @(posedge clk);
    if (rst_n) model_step(ls, lw, li, ld, rs, rw, ri, rdd);
  endtask

  task automatic peek(int li, int ri, string req);
    cyc(0, 0, li, 0, 0, 0, ri, 0, req);
  endtask

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mo[i] = 0; mpl[i] = 0; mpr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state on every index
    for (int i = 0; i < N; i++) peek(i, N-1-i, "R9");
    // R4 grant on free flag, R5 read back
    cyc(1, 1, 2, 0, 0, 0, 2, 0, "R4");
    peek(2, 2, "R5");
    check("R5 left owns", l_rd, 1'b0);
    check("R5 right sees busy", r_rd, 1'b1);
    // R1 other flags unaffected
    peek(3, 1, "R1");
    // R2 writes without strobe ignored
    cyc(0, 1, 2, 1, 0, 1, 2, 0, "R2");
    cyc(1, 0, 2, 1, 1, 0, 5, 0, "R2");
    peek(2, 5, "R2");
    check("R2 still owned", l_rd, 1'b0);
    // R6 pending then handoff
    cyc(0, 0, 2, 0, 1, 1, 2, 0, "R6");
    peek(2, 2, "R6");
    check("R6 right pending", r_rd, 1'b1);
    cyc(1, 1, 2, 1, 0, 0, 2, 0, "R6");
    peek(2, 2, "R6");
    check("R6 right granted", r_rd, 1'b0);
    // R8 non-owner release does not free
    cyc(1, 1, 2, 1, 0, 0, 2, 0, "R8");
    peek(2, 2, "R8");
    check("R8 owner kept", r_rd, 1'b0);
    // R8 withdrawal of pending request
    cyc(1, 1, 2, 0, 0, 0, 2, 0, "R8");
    cyc(1, 1, 2, 1, 0, 0, 2, 0, "R8");
    cyc(0, 0, 2, 0, 1, 1, 2, 1, "R8");
    peek(2, 2, "R8");
    check("R8 withdrawn stays free", l_rd, 1'b1);
    // R7 exact tie
    cyc(1, 1, 6, 0, 1, 1, 6, 0, "R7");
    peek(6, 6, "R7");
    check("R7 left wins", l_rd, 1'b0);
    cyc(1, 1, 6, 1, 0, 0, 6, 0, "R7");
    peek(6, 6, "R7");
    check("R7 right gets after", r_rd, 1'b0);
    cyc(0, 0, 6, 0, 1, 1, 6, 1, "R7");
    // R3 random mix
    void'($urandom(32'h5eed));
    for (int k = 0; k < 4000; k++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 2), $urandom_range(0, 1),
          $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 2), $urandom_range(0, 1), "R3");
    end
    for (int i = 0; i < N; i++) peek(i, i, "R1");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule